// File: doc/BRIEF.md
# Masked Vector Parametric ReLU Unit

This unit applies a leaky rectifier with a learnable slope to every lane of a half-precision vector. Each lane carries its own slope value. A lane whose input is zero or positive passes that input through unchanged. A lane whose input is negative returns the product of the input and the lane's slope. A predicate mask picks the lanes that take part. A lane whose mask bit is clear produces a zero word.

The unit is a free-running three-stage pipeline and takes one vector on every clock. A valid strobe travels alongside the data. The half-precision multiplier is built into each lane:
- Stage one registers the operands.
- Stage two forms the significand product and the exponent sum.
- Stage three normalises and rounds the product, selects the lane result and registers it.

Software sees the lane count as a parameter. Lane i occupies bits [16i+15:16i] of each data vector and bit i of the mask.

Top module: `prelu_vec`

## Requirements
- R1: For an active lane whose input has a clear sign bit and is not a NaN (exponent field 31 with a non-zero fraction), the output equals the input bit for bit. The input 16'h8000 (negative zero) is also passed through unchanged.
- R2: For any other active lane, the output is the lane's own slope multiplied by the lane's input, rounded to nearest with ties to even. The slope comes from the same lane position as the input.
- R3: A lane whose mask bit is 0 outputs 16'h0000, whatever its input and slope.
- R4: On the multiply path, the output is the canonical quiet NaN 16'h7E00 in three cases: either operand is a NaN, or an infinity meets a zero, or an infinity meets a subnormal.
- R5: On the multiply path, subnormal operands (exponent field 0) count as zero. A product whose unrounded biased exponent is below 1 is flushed to zero. Every zero result carries the XOR of the operand signs.
- R6: On the multiply path, a rounded biased exponent of 31 or more gives infinity with the XOR of the operand signs. An infinity times a non-zero finite operand gives the same signed infinity.
- R7: A vector accepted with in_valid high appears on out_y with out_valid high exactly 3 clock cycles later. Back-to-back vectors are accepted on every cycle. out_valid is never high without a matching accepted vector.
- R8: While the synchronous reset is high, out_valid and out_y are 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks an input vector to be processed |
| in_x | input | 16*LANES | Half-precision input lanes |
| in_slope | input | 16*LANES | Half-precision per-lane slope |
| in_mask | input | LANES | Lane enable, 1 = active |
| out_valid | output | 1 | Marks a result vector |
| out_y | output | 16*LANES | Half-precision result lanes |

## Verification
The bench builds the unit with LANES = 8. At that width, all 65536 input encodings fit into 8192 vectors. This allows three sweeps:
- Every input code against a set of special and ordinary slopes.
- Every slope code against a set of negative, subnormal, infinite and NaN inputs.
- All 256 mask patterns.

Every lane is compared with an arithmetic reference that works on real numbers. Streaming with idle gaps exposes both the latency and back-to-back acceptance.

// File: rtl/prelu_pkg.sv
package prelu_pkg;
  localparam int HW   = 16;
  localparam int EW   = 5;
  localparam int FW   = 10;
  localparam int MW   = FW + 1;
  localparam int PW   = 2 * MW;
  localparam int XW   = EW + 2;
  localparam int BIAS = 15;
  localparam logic [HW-1:0] QNAN = 16'h7E00;
  localparam logic [EW-1:0] EMAX = '1;

  typedef struct packed {
    logic          sign;
    logic          nan;
    logic          inf;
    logic          zero;
    logic [EW-1:0] exp;
    logic [FW-1:0] frac;
  } hcls_t;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_NAN  = 2'd1,
    SP_INF  = 2'd2,
    SP_ZERO = 2'd3
  } spec_e;

  typedef struct packed {
    logic          sign;
    spec_e         spec;
    logic [XW-1:0] exp;
    logic [PW-1:0] prod;
  } mulmid_t;

  function automatic hcls_t classify(input logic [HW-1:0] h);
    hcls_t c;
    c.sign = h[HW-1];
    c.exp  = h[HW-2:FW];
    c.frac = h[FW-1:0];
    c.nan  = (c.exp == EMAX) && (c.frac != '0);
    c.inf  = (c.exp == EMAX) && (c.frac == '0);
    c.zero = (c.exp == '0);
    return c;
  endfunction

  function automatic logic passes(input logic [HW-1:0] h);
    hcls_t c;
    c = classify(h);
    return (!c.sign && !c.nan) || (h == {1'b1, {(HW-1){1'b0}}});
  endfunction
endpackage

// File: rtl/prelu_hmul_front.sv
module prelu_hmul_front
  import prelu_pkg::*;
(
  input  logic [HW-1:0] a,
  input  logic [HW-1:0] x,
  output mulmid_t       mid
);
  hcls_t ca, cx;
  logic signed [XW-1:0] esum;

  always_comb begin
    ca   = classify(a);
    cx   = classify(x);
    esum = $signed({2'b00, ca.exp}) + $signed({2'b00, cx.exp}) - XW'(BIAS);
    mid.sign = ca.sign ^ cx.sign;
    mid.exp  = esum;
    mid.prod = PW'({1'b1, ca.frac}) * PW'({1'b1, cx.frac});
    if (ca.nan || cx.nan || (ca.inf && cx.zero) || (cx.inf && ca.zero))
      mid.spec = SP_NAN;
    else if (ca.inf || cx.inf)
      mid.spec = SP_INF;
    else if (ca.zero || cx.zero)
      mid.spec = SP_ZERO;
    else
      mid.spec = SP_NONE;
  end
endmodule

// File: rtl/prelu_hmul_back.sv
module prelu_hmul_back
  import prelu_pkg::*;
(
  input  mulmid_t       mid,
  output logic [HW-1:0] y
);
  logic                  hi;
  logic [MW-1:0]         keep;
  logic                  rbit;
  logic                  sticky;
  logic [MW:0]           rnd;
  logic signed [XW:0]    e0;
  logic signed [XW:0]    e1;
  logic [FW-1:0]         frac;

  always_comb begin
    hi     = mid.prod[PW-1];
    keep   = hi ? mid.prod[PW-1 -: MW] : mid.prod[PW-2 -: MW];
    rbit   = hi ? mid.prod[PW-1-MW] : mid.prod[PW-2-MW];
    sticky = hi ? (|mid.prod[PW-2-MW:0]) : (|mid.prod[PW-3-MW:0]);
    e0     = $signed({mid.exp[XW-1], mid.exp}) + (hi ? (XW+1)'(1) : (XW+1)'(0));
    rnd    = {1'b0, keep} + {{MW{1'b0}}, (rbit & (sticky | keep[0]))};
    if (rnd[MW]) begin
      e1   = e0 + (XW+1)'(1);
      frac = '0;
    end else begin
      e1   = e0;
      frac = rnd[FW-1:0];
    end
    unique case (mid.spec)
      SP_NAN:  y = QNAN;
      SP_INF:  y = {mid.sign, EMAX, {FW{1'b0}}};
      SP_ZERO: y = {mid.sign, {(HW-1){1'b0}}};
      default: begin
        if (e0 < (XW+1)'(1))
          y = {mid.sign, {(HW-1){1'b0}}};
        else if (e1 >= $signed((XW+1)'(EMAX)))
          y = {mid.sign, EMAX, {FW{1'b0}}};
        else
          y = {mid.sign, e1[EW-1:0], frac};
      end
    endcase
  end
endmodule

// File: rtl/prelu_lane.sv
module prelu_lane
  import prelu_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] x,
  input  logic [HW-1:0] a,
  input  logic          m,
  output logic [HW-1:0] y
);
  // stage 1: operand capture
  logic [HW-1:0] x1, a1;
  logic          m1;
  // stage 2: product before rounding
  logic [HW-1:0] x2;
  logic          m2, pass2;
  mulmid_t       mid1, mid2;
  logic [HW-1:0] prod2, sel2;

  always_ff @(posedge clk) begin
    x1 <= x;
    a1 <= a;
    m1 <= m;
  end

  prelu_hmul_front u_front (.a(a1), .x(x1), .mid(mid1));

  always_ff @(posedge clk) begin
    x2    <= x1;
    m2    <= m1;
    pass2 <= passes(x1);
    mid2  <= mid1;
  end

  prelu_hmul_back u_back (.mid(mid2), .y(prod2));

  always_comb begin
    if (!m2)       sel2 = '0;
    else if (pass2) sel2 = x2;
    else           sel2 = prod2;
  end

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else     y <= sel2;
  end
endmodule

// File: rtl/prelu_vec.sv
module prelu_vec
  import prelu_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [HW*LANES-1:0] in_x,
  input  logic [HW*LANES-1:0] in_slope,
  input  logic [LANES-1:0]    in_mask,
  output logic                out_valid,
  output logic [HW*LANES-1:0] out_y
);
  localparam int LAT = 3;

  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  assign out_valid = vpipe[LAT-1];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    prelu_lane u_lane (
      .clk (clk),
      .rst (rst),
      .x   (in_x[l*HW +: HW]),
      .a   (in_slope[l*HW +: HW]),
      .m   (in_mask[l]),
      .y   (out_y[l*HW +: HW])
    );
  end
endmodule

// File: rtl/prelu_vec_chk.sv
module prelu_vec_chk
  import prelu_pkg::*;
#(
  parameter int LANES = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [HW*LANES-1:0] in_x,
  input logic [HW*LANES-1:0] in_slope,
  input logic [LANES-1:0]    in_mask,
  input logic                out_valid,
  input logic [HW*LANES-1:0] out_y
);
  logic [1:0]          since;
  logic [HW*LANES-1:0] xd1, xd2, xd3;
  logic [LANES-1:0]    md1, md2, md3;
  logic [2:0]          vd;
  logic [LANES-1:0]    bad_mask, bad_pass, bad_nan;
  logic                armed;

  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
    xd1 <= in_x;  xd2 <= xd1; xd3 <= xd2;
    md1 <= in_mask; md2 <= md1; md3 <= md2;
    vd  <= {vd[1:0], in_valid};
  end

  assign armed = (since == 2'd3);

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [HW-1:0] xv, yv;
      hcls_t cx;
      xv = xd3[l*HW +: HW];
      yv = out_y[l*HW +: HW];
      cx = classify(xv);
      bad_mask[l] = !md3[l] && (yv != '0);
      bad_pass[l] = md3[l] && ((!cx.sign && !cx.nan) || xv == 16'h8000) && (yv != xv);
      bad_nan[l]  = md3[l] && cx.nan && (yv != QNAN);
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == vd[2]));                                    // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && out_y == '0));                               // R8
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid) |-> (bad_mask == '0));                         // R3
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid) |-> (bad_pass == '0));                         // R1
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (rst)
    (armed && out_valid) |-> (bad_nan == '0));                          // R4
endmodule

bind prelu_vec prelu_vec_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
  .in_slope(in_slope), .in_mask(in_mask), .out_valid(out_valid), .out_y(out_y)
);

// File: tb/sim_prelu_vec.sv
`timescale 1ns/1ps
module sim_prelu_vec;
  localparam int L  = 8;
  localparam int VW = 16 * L;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_x = '0, in_slope = '0;
  logic [L-1:0]  in_mask = '0;
  logic          out_valid;
  logic [VW-1:0] out_y;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  logic [VW-1:0] qx[$], qa[$];
  logic [L-1:0]  qm[$];
  int            qc[$];

  prelu_vec #(.LANES(L)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_slope(in_slope),
    .in_mask(in_mask), .out_valid(out_valid), .out_y(out_y)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic real pow2(input int k);
    real r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else repeat (-k) r = r / 2.0;
    return r;
  endfunction

  function automatic bit is_nan(input logic [15:0] h);
    return h[14:10] == 5'h1f && h[9:0] != 0;
  endfunction

  // arithmetic model of the slope product
  function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] x);
    logic s = a[15] ^ x[15];
    bit ai = a[14:0] == 15'h7c00, xi = x[14:0] == 15'h7c00;
    bit az = a[14:10] == 0, xz = x[14:10] == 0;
    real mag, m, fr;
    int e, ex, mi;
    if (is_nan(a) || is_nan(x) || (ai && xz) || (xi && az)) return 16'h7E00;
    if (ai || xi) return {s, 15'h7c00};
    if (az || xz) return {s, 15'h0};
    mag = real'(1024 + a[9:0]) * real'(1024 + x[9:0]) * pow2(int'(a[14:10]) + int'(x[14:10]) - 50);
    e = 0;
    while (mag >= 2.0) begin mag = mag / 2.0; e++; end
    while (mag < 1.0)  begin mag = mag * 2.0; e--; end
    ex = e + 15;
    if (ex < 1) return {s, 15'h0};
    m  = mag * 1024.0;
    mi = int'($floor(m));
    fr = m - real'(mi);
    if (fr > 0.5 || (fr == 0.5 && (mi % 2) == 1)) mi++;
    if (mi == 2048) begin mi = 1024; ex++; end
    if (ex >= 31) return {s, 15'h7c00};
    return {s, 5'(ex), 10'(mi)};
  endfunction

  function automatic logic [15:0] ref_lane(input logic [15:0] x, input logic [15:0] a, input logic m);
    if (!m) return 16'h0;
    if ((!x[15] && !is_nan(x)) || x == 16'h8000) return x;
    return ref_mul(a, x);
  endfunction

  function automatic string tag_of(input logic [15:0] x, input logic [15:0] a,
                                   input logic m, input logic [15:0] e);
    if (!m) return "R3";
    if ((!x[15] && !is_nan(x)) || x == 16'h8000) return "R1";
    if (e == 16'h7E00) return "R4";
    if (e[14:0] == 15'h7c00) return "R6";
    if (e[14:0] == 15'h0) return "R5";
    return "R2";
  endfunction

  task automatic issue(input logic [VW-1:0] x, input logic [VW-1:0] a, input logic [L-1:0] m);
    @(negedge clk);
    in_valid = 1'b1; in_x = x; in_slope = a; in_mask = m;
    qx.push_back(x); qa.push_back(a); qm.push_back(m); qc.push_back(cyc);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_x = {L{16'hDEAD}};
  endtask

  // monitor: every returned vector is compared lane by lane
  always @(negedge clk) begin
    if (!rst && !done && out_valid) begin
      if (qx.size() == 0) begin
        errors++; checks++;
        $display("FAIL R7: out_valid=1 expected 0 (no vector pending)");
      end else begin
        logic [VW-1:0] x, a;
        logic [L-1:0]  m;
        int c;
        x = qx.pop_front(); a = qa.pop_front(); m = qm.pop_front(); c = qc.pop_front();
        checks++;
        if (cyc != c + 3) begin
          errors++;
          $display("FAIL R7: latency actual=%0d expected=3", cyc - c);
        end
        for (int l = 0; l < L; l++) begin
          logic [15:0] e, g;
          e = ref_lane(x[l*16 +: 16], a[l*16 +: 16], m[l]);
          g = out_y[l*16 +: 16];
          checks++;
          if (g !== e) begin
            errors++;
            $display("FAIL %s: lane %0d x=%h a=%h m=%b actual=%h expected=%h",
                     tag_of(x[l*16 +: 16], a[l*16 +: 16], m[l], e), l,
                     x[l*16 +: 16], a[l*16 +: 16], m[l], g, e);
          end
        end
      end
    end
  end

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t = v;
    t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(1900000);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] slopes [9] = '{16'h3800, 16'h3C00, 16'hC000, 16'h7BFF, 16'h0000,
                                16'h7C00, 16'h7D00, 16'h0001, 16'h1400};
    logic [15:0] xneg [8] = '{16'hBC00, 16'hC500, 16'h8001, 16'hFBFF,
                              16'hFC00, 16'h8400, 16'hB555, 16'hFE00};
    logic [31:0] seed = 32'h1234_5678;

    repeat (3) @(negedge clk);
    // R8: registered outputs cleared during reset
    checks++;
    if (out_valid !== 1'b0 || out_y !== '0) begin
      errors++;
      $display("FAIL R8: out_valid=%b out_y=%h expected 0/0", out_valid, out_y);
    end
    @(negedge clk); rst = 1'b0;

    // all input codes against a rotating slope set (R1,R2,R4,R5,R6)
    for (int s = 0; s < 9; s++) begin
      for (int v = 0; v < 8192; v++) begin
        logic [VW-1:0] x, a;
        for (int l = 0; l < L; l++) begin
          x[l*16 +: 16] = 16'(v * 8 + l);
          a[l*16 +: 16] = slopes[(s + l) % 9];
        end
        issue(x, a, '1);
      end
    end

    // all slope codes against difficult negative inputs (R2,R4,R5,R6)
    for (int v = 0; v < 8192; v++) begin
      logic [VW-1:0] x, a;
      for (int l = 0; l < L; l++) begin
        a[l*16 +: 16] = 16'(v * 8 + l);
        x[l*16 +: 16] = xneg[(v + l) % 8];
      end
      issue(x, a, '1);
    end

    // all mask patterns with random data and idle gaps (R3,R7)
    for (int p = 0; p < 256; p++) begin
      logic [VW-1:0] x, a;
      for (int l = 0; l < L; l++) begin
        seed = xs(seed); x[l*16 +: 16] = seed[15:0]; a[l*16 +: 16] = seed[31:16];
      end
      issue(x, a, 8'(p));
      if (p % 7 == 3) idle();
    end

    idle();
    repeat (6) @(negedge clk);
    // R7: every accepted vector came back
    checks++;
    if (qx.size() != 0) begin
      errors++;
      $display("FAIL R7: pending vectors actual=%0d expected=0", qx.size());
    end
    finish_run();
  end
endmodule